// File: doc/BRIEF.md
# Packed-Write Colour Palette Loader

This block holds a 256-entry colour lookup table whose entries carry 8-bit red, green and blue values. A host on a 32-bit bus first sets an index through an address register and then streams data words in which the palette entries sit back to back with no padding. Three data words carry exactly four entries, so an entry often starts in one word and ends in the next. The block takes each word apart, keeps the unfinished entry in a holding register, and writes each entry into storage once its last component has arrived.

A pixel-index lookup port reads the table with a registered, one-cycle latency and returns a 24-bit colour. The same address register also selects one of the DAC setup registers. The host writes a byte to these registers through a separate control select. The four setup registers are shown packed on one output bus.

Top module: `pal_loader`

## Requirements
- R1: On reset every palette entry reads back as 0, `lut_rgb` is 0, and `dac_cfg` is 32'hFF007000. Setup register 4 is in bits 31:24, register 5 in bits 23:16, register 6 in bits 15:8 and register 7 in bits 7:0.
- R2: A host write with `host_sel` = 2'b00 (address) loads `host_wdata[7:0]` as the current index. The palette stream then restarts at the group base, which is that index rounded down to a multiple of 4, with the next data word treated as the first of a group.
- R3: With `host_sel` = 2'b01 (data), bytes are taken most significant first. The 12 bytes of a group are red, green, blue of base+0, then base+1, base+2 and base+3 in turn. Word 0 holds R0 G0 B0 R1, word 1 holds G1 B1 R2 G2, and word 2 holds B2 R3 G3 B3.
- R4: An entry is written to storage only in the cycle that its last component arrives. Entries whose components are still partly outstanding keep their old value.
- R5: After the third data word of a group, the group base advances by 4 and the next word starts a new group. The base wraps from entry 252 to entry 0.
- R6: The colour of entry `lut_idx` appears on `lut_rgb` after the next rising clock edge, with `lut_rgb[23:16]` red, `[15:8]` green and `[7:0]` blue.
- R7: When a lookup and a host data write hit the same entry at the same edge, `lut_rgb` returns the value held before the write. The new value appears on the following lookup.
- R8: A write with `host_sel` = 2'b10 (control) stores `host_wdata[7:0]` into setup register n when the current index n is 4 to 7, and has no effect for any other index. Neither this write nor `host_sel` = 2'b11 changes the position in the palette stream.
- R9: Cycles with `host_wr` low, and writes with `host_sel` = 2'b11, change neither the palette nor the setup registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one write per cycle |
| host_sel | input | 2 | Write target: 00 address, 01 palette data, 10 setup byte, 11 reserved |
| host_wdata | input | 32 | Host write data |
| lut_idx | input | 8 | Pixel index to look up |
| lut_rgb | output | 24 | Registered colour of the looked-up entry |
| dac_cfg | output | 32 | DAC setup registers 4 to 7 packed, register 4 in the top byte |

## Verification
Groups are loaded from unaligned start indices to show that the base is rounded down. A stream is stopped after each word to tell the one-word-complete entries apart from the entries split across words. A stream running over the last group shows the group advance and the wrap to entry 0. Setup writes and reserved writes are placed between the data words of a stream, which separates a correct stream position from a disturbed one. A lookup that hits the entry being written in the same cycle shows whether the old or the new value is returned.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int CW       = 8;          // bits per colour component
    localparam int RGB_W    = 3 * CW;
    localparam int BUS_W    = 32;
    localparam int GRP_SIZE = 4;          // entries per packed group
    localparam int GRP_WORDS = 3;         // bus words per group
    localparam int N_SETUP  = 4;          // setup registers, indices 4..7

    typedef enum logic [1:0] {
        SEL_ADDR = 2'b00,
        SEL_DATA = 2'b01,
        SEL_CTRL = 2'b10,
        SEL_RSVD = 2'b11
    } host_sel_e;

    function automatic logic [CW-1:0] setup_init(input int n);
        case (n)
            0: setup_init = 8'hFF;
            2: setup_init = 8'h70;
            default: setup_init = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/pal_unpack.sv
module pal_unpack
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [1:0]             sel,
    input  logic [BUS_W-1:0]       wdata,
    output logic                   we_a,
    output logic [IDX_W-1:0]       idx_a,
    output logic [RGB_W-1:0]       rgb_a,
    output logic                   we_b,
    output logic [IDX_W-1:0]       idx_b,
    output logic [RGB_W-1:0]       rgb_b,
    output logic [IDX_W-1:0]       cur_idx,
    output logic [1:0]             phase,
    output logic [IDX_W-3:0]       grp
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [IDX_W-3:0] grp;
        logic [1:0]       phase;
        logic [2*CW-1:0]  hold;
    } unp_state_t;

    unp_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        we_a  = 1'b0;
        we_b  = 1'b0;
        idx_a = {st_q.grp, 2'd0};
        idx_b = {st_q.grp, 2'd3};
        rgb_a = '0;
        rgb_b = '0;
        if (wr && sel == SEL_ADDR) begin
            st_d.idx   = wdata[IDX_W-1:0];
            st_d.grp   = wdata[IDX_W-1:2];
            st_d.phase = 2'd0;
        end else if (wr && sel == SEL_DATA) begin
            case (st_q.phase)
                2'd0: begin
                    we_a            = 1'b1;
                    idx_a           = {st_q.grp, 2'd0};
                    rgb_a           = wdata[31:8];
                    st_d.hold[15:8] = wdata[7:0];
                    st_d.phase      = 2'd1;
                end
                2'd1: begin
                    we_a       = 1'b1;
                    idx_a      = {st_q.grp, 2'd1};
                    rgb_a      = {st_q.hold[15:8], wdata[31:16]};
                    st_d.hold  = wdata[15:0];
                    st_d.phase = 2'd2;
                end
                2'd2: begin
                    we_a       = 1'b1;
                    idx_a      = {st_q.grp, 2'd2};
                    rgb_a      = {st_q.hold, wdata[31:24]};
                    we_b       = 1'b1;
                    idx_b      = {st_q.grp, 2'd3};
                    rgb_b      = wdata[23:0];
                    st_d.phase = 2'd0;
                    st_d.grp   = st_q.grp + 1'b1;
                end
                default: st_d.phase = 2'd0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_idx = st_q.idx;
    assign phase   = st_q.phase;
    assign grp     = st_q.grp;
endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_a,
    input  logic [IDX_W-1:0] idx_a,
    input  logic [RGB_W-1:0] rgb_a,
    input  logic             we_b,
    input  logic [IDX_W-1:0] idx_b,
    input  logic [RGB_W-1:0] rgb_b,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [RGB_W-1:0] rd_rgb
);
    logic [RGB_W-1:0] mem_q [DEPTH];
    logic [RGB_W-1:0] rd_d, rd_q;

    assign rd_d = mem_q[rd_idx];   // value before any write at this edge

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            rd_q <= '0;
        end else begin
            if (we_a) mem_q[idx_a] <= rgb_a;
            if (we_b) mem_q[idx_b] <= rgb_b;
            rd_q <= rd_d;
        end
    end

    assign rd_rgb = rd_q;
endmodule

// File: rtl/pal_setup.sv
module pal_setup
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [1:0]            sel,
    input  logic [CW-1:0]         wbyte,
    input  logic [IDX_W-1:0]      cur_idx,
    output logic [N_SETUP*CW-1:0] cfg
);
    localparam logic [IDX_W-3:0] SETUP_GRP = 1;

    logic [CW-1:0] reg_d [N_SETUP];
    logic [CW-1:0] reg_q [N_SETUP];
    logic          hit;

    assign hit = wr && sel == SEL_CTRL && cur_idx[IDX_W-1:2] == SETUP_GRP;

    always_comb begin
        for (int i = 0; i < N_SETUP; i++) reg_d[i] = reg_q[i];
        if (hit) reg_d[cur_idx[1:0]] = wbyte;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_SETUP; i++) begin
            if (!rst_n) reg_q[i] <= setup_init(i);
            else        reg_q[i] <= reg_d[i];
        end
    end

    for (genvar g = 0; g < N_SETUP; g++) begin : g_pack
        assign cfg[(N_SETUP-g)*CW-1 -: CW] = reg_q[g];
    end
endmodule

// File: rtl/pal_loader.sv
module pal_loader
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [1:0]       host_sel,
    input  logic [31:0]      host_wdata,
    input  logic [7:0]       lut_idx,
    output logic [23:0]      lut_rgb,
    output logic [31:0]      dac_cfg
);
    logic             we_a, we_b;
    logic [IDX_W-1:0] idx_a, idx_b, cur_idx;
    logic [RGB_W-1:0] rgb_a, rgb_b;
    logic [1:0]       cur_phase;
    logic [IDX_W-3:0] cur_grp;

    pal_unpack #(.IDX_W(IDX_W)) u_unpack (
        .clk(clk), .rst_n(rst_n), .wr(host_wr), .sel(host_sel),
        .wdata(host_wdata),
        .we_a(we_a), .idx_a(idx_a), .rgb_a(rgb_a),
        .we_b(we_b), .idx_b(idx_b), .rgb_b(rgb_b),
        .cur_idx(cur_idx), .phase(cur_phase), .grp(cur_grp)
    );

    pal_store #(.IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we_a(we_a), .idx_a(idx_a), .rgb_a(rgb_a),
        .we_b(we_b), .idx_b(idx_b), .rgb_b(rgb_b),
        .rd_idx(lut_idx), .rd_rgb(lut_rgb)
    );

    pal_setup #(.IDX_W(IDX_W)) u_setup (
        .clk(clk), .rst_n(rst_n), .wr(host_wr), .sel(host_sel),
        .wbyte(host_wdata[CW-1:0]), .cur_idx(cur_idx), .cfg(dac_cfg)
    );
endmodule

// File: rtl/pal_loader_chk.sv
module pal_loader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic [1:0]  host_sel,
    input logic [31:0] dac_cfg,
    input logic [1:0]  phase,
    input logic [5:0]  grp
);
    AST_SETUP_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> dac_cfg == 32'hFF007000); // R1
    AST_ADDR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_sel == 2'b00 |=> phase == 2'd0); // R2
    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 2'd3); // R5
    AST_GROUP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_sel == 2'b01 && phase == 2'd2
        |=> phase == 2'd0 && grp == 6'($past(grp) + 6'd1)); // R5
    AST_SETUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_sel == 2'b10) |=> $stable(dac_cfg)); // R8
    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && (host_sel == 2'b00 || host_sel == 2'b01))
        |=> $stable(phase) && $stable(grp)); // R9
endmodule

bind pal_loader pal_loader_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .dac_cfg(dac_cfg), .phase(cur_phase), .grp(cur_grp)
);

// File: tb/pal_loader_bench.sv
module pal_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_sel = 2'b00;
    logic [31:0] host_wdata = '0;
    logic [7:0]  lut_idx = '0;
    logic [23:0] lut_rgb;
    logic [31:0] dac_cfg;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [23:0] exp_pal [256];
    logic [31:0] exp_cfg;

    always #5 clk = ~clk;

    pal_loader u_pal_loader (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .lut_idx(lut_idx), .lut_rgb(lut_rgb),
        .dac_cfg(dac_cfg)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic host(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic look(input int idx, output logic [23:0] rgb);
        @(negedge clk);
        lut_idx = 8'(idx);
        @(negedge clk);
        rgb = lut_rgb;
    endtask

    task automatic chk_entry(input string req, input int idx);
        logic [23:0] v;
        look(idx, v);
        chk(req, {8'h0, v}, {8'h0, exp_pal[idx]});
    endtask

    function automatic logic [95:0] pack4(input int seed);
        return {24'(seed * 24'h010203 + 24'h102030), 24'(seed * 24'h050607 + 24'h445566),
                24'(seed * 24'h0A0B0C + 24'h778899), 24'(seed * 24'h111213 + 24'hABCDEF)};
    endfunction

    task automatic model_group(input int base, input logic [95:0] g);
        exp_pal[base]                 = g[95:72];
        exp_pal[(base + 1) % 256]     = g[71:48];
        exp_pal[(base + 2) % 256]     = g[47:24];
        exp_pal[(base + 3) % 256]     = g[23:0];
    endtask

    task automatic t_reset;
        chk_entry("R1 entry0", 0);
        chk_entry("R1 entry255", 255);
        chk("R1 setup", dac_cfg, 32'hFF007000);
    endtask

    task automatic t_group;
        logic [95:0] g = pack4(1);
        host(2'b00, 32'd6);                 // rounds down to 4
        host(2'b01, g[95:64]);
        host(2'b01, g[63:32]);
        host(2'b01, g[31:0]);
        model_group(4, g);
        for (int i = 4; i < 8; i++) chk_entry("R2 R3 group at 4", i);
        chk_entry("R2 entry 8 untouched", 8);
    endtask

    task automatic t_partial;
        logic [95:0] g = pack4(2);
        host(2'b00, 32'd22);                // base 20
        host(2'b01, g[95:64]);
        exp_pal[20] = g[95:72];
        chk_entry("R4 word0 commits e0", 20);
        chk_entry("R4 e1 still old", 21);
        host(2'b11, 32'hDEADBEEF);          // reserved, ignored
        host(2'b01, g[63:32]);
        exp_pal[21] = g[71:48];
        chk_entry("R4 word1 commits e1", 21);
        chk_entry("R4 e2 still old", 22);
        host(2'b10, 32'h0000005A);          // index 22 is not a setup reg
        chk("R8 index 22 ignored", dac_cfg, exp_cfg);
        host(2'b01, g[31:0]);
        exp_pal[22] = g[47:24]; exp_pal[23] = g[23:0];
        chk_entry("R9 R8 stream intact e2", 22);
        chk_entry("R3 stream intact e3", 23);
    endtask

    task automatic t_wrap;
        logic [95:0] g0 = pack4(3);
        logic [95:0] g1 = pack4(4);
        host(2'b00, 32'd253);               // base 252
        host(2'b01, g0[95:64]); host(2'b01, g0[63:32]); host(2'b01, g0[31:0]);
        host(2'b01, g1[95:64]); host(2'b01, g1[63:32]); host(2'b01, g1[31:0]);
        model_group(252, g0);
        model_group(0, g1);
        chk_entry("R5 entry252", 252);
        chk_entry("R5 entry255", 255);
        chk_entry("R5 wrap entry0", 0);
        chk_entry("R5 wrap entry3", 3);
    endtask

    task automatic t_collision;
        logic [95:0] g = pack4(5);
        logic [23:0] old = exp_pal[40];
        host(2'b00, 32'd40);
        @(negedge clk);
        host_wr = 1'b1; host_sel = 2'b01; host_wdata = g[95:64]; lut_idx = 8'd40;
        @(negedge clk);
        host_wr = 1'b0;
        chk("R7 same-entry read returns old", {8'h0, lut_rgb}, {8'h0, old});
        @(negedge clk);
        chk("R6 next lookup returns new", {8'h0, lut_rgb}, {8'h0, g[95:72]});
        exp_pal[40] = g[95:72];
    endtask

    task automatic t_setup;
        host(2'b00, 32'd5);  host(2'b10, 32'h123456AB);
        exp_cfg[23:16] = 8'hAB;
        chk("R8 write reg5", dac_cfg, exp_cfg);
        host(2'b00, 32'd7);  host(2'b10, 32'h00000033);
        exp_cfg[7:0] = 8'h33;
        chk("R8 write reg7", dac_cfg, exp_cfg);
        host(2'b00, 32'd132); host(2'b10, 32'h00000099);
        chk("R8 index 132 ignored", dac_cfg, exp_cfg);
        host(2'b00, 32'd4);  host(2'b11, 32'h00000077);
        chk("R9 reserved select ignored", dac_cfg, exp_cfg);
        @(negedge clk);
        host_sel = 2'b10; host_wdata = 32'h00000011;   // strobe low
        @(negedge clk);
        chk("R9 strobe low ignored", dac_cfg, exp_cfg);
        host_sel = 2'b01;
        @(negedge clk);
        chk_entry("R9 strobe low leaves entry4", 4);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) exp_pal[i] = '0;
        exp_cfg = 32'hFF007000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_group();
        t_partial();
        t_wrap();
        t_collision();
        t_setup();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule